// File: doc/BRIEF.md
# Multiplexed LED Matrix Driver

This block lights a 64-LED array wired as eight digit (cathode) lines by eight segment (anode) lines. It pulls one digit line low at a time, stepping through all eight in a fixed order. While a digit is active it drives the segment lines of the LEDs that should be on in that group. Each digit's segment byte comes from its own register. The byte is either used as a raw bit pattern or, when decoding is enabled for that digit, read as a BCD code and turned into a seven-segment numeral. A global 4-bit intensity value blanks the segments for part of every digit slot, which dims the whole array in 16 steps.

The host loads the block over a three-wire serial link made of a shift clock, a data line and a load strobe. Each command is a 16-bit word with an address byte above a data byte, shifted in MSB first. The bit pushed out of the top of the shift register appears on a serial output. Several drivers can therefore be chained, and a single load pulse makes every chip apply the word it currently holds. The three serial inputs are sampled by the block's own clock, so they may be asynchronous to it.

Top module: `led_matrix_drv`

## Requirements
- R1: A word is shifted in MSB first, one bit per rising edge of `ser_clk`. Bits [15:8] are the address and bits [7:0] the data. The word takes effect on the rising edge of `ser_load`.
- R2: `ser_dout` carries bit 15 of the shift register. In a chain of two drivers fed with 32 bits, the first 16 bits end up in the downstream driver, and both drivers apply their words on one load pulse.
- R3: Addresses 0x01 to 0x08 write the segment byte of digits 0 to 7. Digit k is driven on `digit_n[k]`.
- R4: Address 0x09 writes the decode mask, where bit k enables decoding for digit k. Address 0x0A writes the intensity from data bits [3:0]. A load with any other address changes no register and no output.
- R5: Once out of reset, exactly one `digit_n` line is low at any time. Digits are visited in the order 0, 1, ... 7, 0, and each stays active for 16*TICK_DIV clock cycles.
- R6: When a digit's decode bit is 0, `seg` shows that digit's data byte unchanged, with bit 0 on `seg[0]`.
- R7: When a digit's decode bit is 1, `seg[6:0]` shows the numeral for codes 0 to 9 of data bits [3:0], using a=`seg[0]` through g=`seg[6]`. Codes 10 to 15 give all seven segments off. `seg[7]` follows data bit 7, and data bits [6:4] are ignored.
- R8: With intensity I, the pattern is shown during the first (I+1)*TICK_DIV cycles of each digit slot. `seg` is 0 for the rest of the slot.
- R9: While reset is asserted, `digit_n` is all ones and `seg` is all zeros. Reset clears all digit bytes, the decode mask and the intensity, so the array is dark after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_din | input | 1 | Serial data in |
| ser_load | input | 1 | Load strobe; its rising edge applies the held word |
| ser_dout | output | 1 | Serial data out to the next driver in a chain |
| digit_n | output | 8 | Digit lines, active low, at most one low |
| seg | output | 8 | Segment lines, active high |

## Verification
The assertions watch several properties on every cycle. At most one digit line is low. The digit index holds between slot ends and moves at each slot end. Segments are dark whenever the PWM phase lies past the intensity, and the seven numeral segments are dark for an undecodable code. A load with an unknown address leaves every register as it was, and a load without a shift leaves the shift register unchanged. The end-to-end behaviour can only be shown by the bench's scenarios: bit order, chaining through the serial output, the exact pattern for each digit, and the on-time of each slot for a given intensity. The bench observes whole scan frames of two chained drivers and compares every cycle of every slot against its own model.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

  localparam int WORD_W  = 16;
  localparam int SEG_W   = 8;
  localparam int LVL_W   = 4;
  localparam int DIGITS  = 8;

  localparam logic [7:0] ADDR_DECODE = 8'h09;
  localparam logic [7:0] ADDR_LEVEL  = 8'h0A;

  // BCD code to segments a..g on bits 0..6; non-decimal codes are dark
  function automatic logic [6:0] bcd_to_7seg(input logic [3:0] code);
    logic [6:0] s;
    unique case (code)
      4'd0: s = 7'b0111111;
      4'd1: s = 7'b0000110;
      4'd2: s = 7'b1011011;
      4'd3: s = 7'b1001111;
      4'd4: s = 7'b1100110;
      4'd5: s = 7'b1101101;
      4'd6: s = 7'b1111101;
      4'd7: s = 7'b0000111;
      4'd8: s = 7'b1111111;
      4'd9: s = 7'b1101111;
      default: s = 7'b0000000;
    endcase
    return s;
  endfunction

  // Segment byte for one digit: raw, or decoded with bit 7 passed through
  function automatic logic [SEG_W-1:0] seg_pattern(input logic [7:0] data,
                                                   input logic       decode);
    return decode ? {data[7], bcd_to_7seg(data[3:0])} : data;
  endfunction

  // Segments are enabled while the slot phase has not passed the level
  function automatic logic pwm_lit(input logic [LVL_W-1:0] phase,
                                   input logic [LVL_W-1:0] level);
    return phase <= level;
  endfunction

endpackage

// File: rtl/ser_port.sv
module ser_port #(
  parameter int WORD_W = led_drv_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              ser_load,
  output logic              shift_evt,
  output logic              load_evt,
  output logic [WORD_W-1:0] word,
  output logic              ser_dout
);

  logic [2:0]        clk_s;
  logic [2:0]        ld_s;
  logic [1:0]        din_s;
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_s <= '0;
      ld_s  <= '0;
      din_s <= '0;
    end else begin
      clk_s <= {clk_s[1:0], ser_clk};
      ld_s  <= {ld_s[1:0], ser_load};
      din_s <= {din_s[0], ser_din};
    end
  end

  assign shift_evt = clk_s[1] & ~clk_s[2];
  assign load_evt  = ld_s[1] & ~ld_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sr <= '0;
    else if (shift_evt) sr <= {sr[WORD_W-2:0], din_s[1]};
  end

  assign word     = sr;
  assign ser_dout = sr[WORD_W-1];

  // R1: applying a word does not disturb the shift register contents
  a_r1_load_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !shift_evt) |=> $stable(word));

  // R2: the chain output only moves on a shift
  a_r2_dout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(ser_dout));

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import led_drv_pkg::*;
#(
  parameter int NUM_DIG = DIGITS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_evt,
  input  logic [WORD_W-1:0]             word,
  output logic [NUM_DIG-1:0][SEG_W-1:0] dig_data,
  output logic [NUM_DIG-1:0]            decode_mask,
  output logic [LVL_W-1:0]              level,
  output logic                          addr_known
);

  logic [7:0]         addr;
  logic [7:0]         data;
  logic [NUM_DIG-1:0] dig_match;
  logic               dec_match;
  logic               lvl_match;

  assign addr = word[15:8];
  assign data = word[7:0];

  for (genvar k = 0; k < NUM_DIG; k++) begin : g_digit
    assign dig_match[k] = (addr == 8'(k + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       dig_data[k] <= '0;
      else if (load_evt && dig_match[k]) dig_data[k] <= data;
    end
  end

  assign dec_match  = (addr == ADDR_DECODE);
  assign lvl_match  = (addr == ADDR_LEVEL);
  assign addr_known = (|dig_match) | dec_match | lvl_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decode_mask <= '0;
      level       <= '0;
    end else if (load_evt) begin
      if (dec_match) decode_mask <= data[NUM_DIG-1:0];
      if (lvl_match) level       <= data[LVL_W-1:0];
    end
  end

  // R4: a load to an unknown address changes nothing
  a_r4_ignore_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !addr_known) |=>
      ($stable(dig_data) && $stable(decode_mask) && $stable(level)));

  // R3: digit bytes only move on a load
  a_r3_digits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(dig_data));

endmodule

// File: rtl/scan_timer.sv
module scan_timer
  import led_drv_pkg::*;
#(
  parameter int NUM_DIG  = DIGITS,
  parameter int TICK_DIV = 2,
  localparam int DIG_W   = $clog2(NUM_DIG),
  localparam int DIV_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [DIG_W-1:0] dig_idx,
  output logic [LVL_W-1:0] phase,
  output logic             slot_end
);

  logic [DIV_W-1:0] div_cnt;
  logic             tick;

  assign tick     = (div_cnt == DIV_W'(TICK_DIV - 1));
  assign slot_end = tick && (phase == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      phase   <= '0;
      dig_idx <= '0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) phase <= phase + 1'b1;
      if (slot_end)
        dig_idx <= (dig_idx == DIG_W'(NUM_DIG - 1)) ? '0 : dig_idx + 1'b1;
    end
  end

  // R5: a digit stays selected for its whole slot
  a_r5_hold_digit: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> $stable(dig_idx));

  // R5: the digit changes at every slot end
  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> (dig_idx != $past(dig_idx)));

endmodule

// File: rtl/led_matrix_drv.sv
module led_matrix_drv
  import led_drv_pkg::*;
#(
  parameter int NUM_DIG  = DIGITS,
  parameter int TICK_DIV = 2,
  localparam int DIG_W   = $clog2(NUM_DIG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_din,
  input  logic               ser_load,
  output logic               ser_dout,
  output logic [NUM_DIG-1:0] digit_n,
  output logic [SEG_W-1:0]   seg
);

  logic                          shift_evt;
  logic                          load_evt;
  logic [WORD_W-1:0]             word;
  logic [NUM_DIG-1:0][SEG_W-1:0] dig_data;
  logic [NUM_DIG-1:0]            decode_mask;
  logic [LVL_W-1:0]              level;
  logic                          addr_known;
  logic [DIG_W-1:0]              dig_idx;
  logic [LVL_W-1:0]              phase;
  logic                          slot_end;

  ser_port #(.WORD_W(WORD_W)) u_port (
    .clk, .rst_n, .ser_clk, .ser_din, .ser_load,
    .shift_evt, .load_evt, .word, .ser_dout
  );

  cfg_regs #(.NUM_DIG(NUM_DIG)) u_regs (
    .clk, .rst_n, .load_evt, .word,
    .dig_data, .decode_mask, .level, .addr_known
  );

  scan_timer #(.NUM_DIG(NUM_DIG), .TICK_DIV(TICK_DIV)) u_scan (
    .clk, .rst_n, .dig_idx, .phase, .slot_end
  );

  // Named internal events for the checks below
  logic [SEG_W-1:0] cur_data;
  logic             cur_decode;
  logic             lit;
  logic             bad_code;
  logic [SEG_W-1:0] seg_d;

  assign cur_data   = dig_data[dig_idx];
  assign cur_decode = decode_mask[dig_idx];
  assign lit        = pwm_lit(phase, level);
  assign bad_code   = cur_decode && (cur_data[3:0] > 4'd9);
  assign seg_d      = lit ? seg_pattern(cur_data, cur_decode) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      digit_n <= '1;
      seg     <= '0;
    end else begin
      digit_n <= ~(NUM_DIG'(1) << dig_idx);
      seg     <= seg_d;
    end
  end

  // R5: never more than one digit line low
  a_r5_one_digit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~digit_n));

  // R8: segments dark once the phase passes the intensity
  a_r8_pwm_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !lit |=> (seg == '0));

  // R7: non-decimal codes light no numeral segment
  a_r7_bad_code_dark: assert property (@(posedge clk) disable iff (!rst_n)
    bad_code |=> (seg[6:0] == 7'd0));

endmodule

// File: tb/led_matrix_drv_test.sv
module led_matrix_drv_test;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int SLOT       = 16 * TICK_DIV;
  localparam int HOLD       = 3;

  localparam logic [6:0] SEVEN [16] = '{
    7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
    7'h7F, 7'h6F, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_din = 1'b0;
  logic ser_load = 1'b0;
  logic chain;
  logic dout2;
  logic [7:0] dn0, dn1, sg0, sg1;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_dig [2][8];
  logic [7:0] m_dec [2];
  logic [3:0] m_lvl [2];

  always #(CLK_PERIOD / 2) clk = ~clk;

  led_matrix_drv #(.TICK_DIV(TICK_DIV)) uut (
    .clk, .rst_n, .ser_clk, .ser_din, .ser_load,
    .ser_dout(chain), .digit_n(dn0), .seg(sg0));

  led_matrix_drv #(.TICK_DIV(TICK_DIV)) uut2 (
    .clk, .rst_n, .ser_clk, .ser_din(chain), .ser_load,
    .ser_dout(dout2), .digit_n(dn1), .seg(sg1));

  function automatic logic [7:0] exp_pat(input logic [7:0] d, input logic dec);
    logic [7:0] r;
    if (dec) begin
      r[7]   = d[7];
      r[6:0] = SEVEN[d[3:0]];
    end else r = d;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_apply(input int c, input logic [15:0] w);
    logic [7:0] a;
    a = w[15:8];
    if (a >= 8'd1 && a <= 8'd8) m_dig[c][a - 8'd1] = w[7:0];
    else if (a == 8'h09) m_dec[c] = w[7:0];
    else if (a == 8'h0A) m_lvl[c] = w[3:0];
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // wd goes to the downstream driver, wu to the upstream one
  task automatic xfer(input logic [15:0] wu, input logic [15:0] wd);
    logic [31:0] stream;
    stream = {wd, wu};
    for (int i = 31; i >= 0; i--) begin
      ser_din = stream[i];
      wait_clk(HOLD);
      ser_clk = 1'b1;
      wait_clk(HOLD);
      ser_clk = 1'b0;
    end
    wait_clk(HOLD);
    ser_load = 1'b1;
    wait_clk(HOLD);
    ser_load = 1'b0;
    wait_clk(HOLD);
    model_apply(0, wu);
    model_apply(1, wd);
  endtask

  task automatic observe(input string req);
    int bad [2];
    logic [7:0] pat [2];
    logic [7:0] eseg;
    logic [7:0] last_bad_a [2];
    logic [7:0] last_bad_e [2];
    do @(negedge clk); while (dn0 != ~8'h80);
    do @(negedge clk); while (dn0 == ~8'h80);
    for (int k = 0; k < 8; k++) begin
      bad[0] = 0; bad[1] = 0;
      last_bad_a[0] = '0; last_bad_a[1] = '0;
      last_bad_e[0] = '0; last_bad_e[1] = '0;
      for (int c = 0; c < 2; c++) pat[c] = exp_pat(m_dig[c][k], m_dec[c][k]);
      for (int j = 0; j < SLOT; j++) begin
        if (!(k == 0 && j == 0)) @(negedge clk);
        for (int c = 0; c < 2; c++) begin
          eseg = (j < (int'(m_lvl[c]) + 1) * TICK_DIV) ? pat[c] : 8'h00;
          if ((c == 0 ? dn0 : dn1) != ~(8'h01 << k) ||
              (c == 0 ? sg0 : sg1) != eseg) begin
            bad[c]++;
            last_bad_a[c] = (c == 0) ? sg0 : sg1;
            last_bad_e[c] = eseg;
          end
        end
      end
      check(bad[0] == 0, req, $sformatf("upstream digit %0d slot (R5 R8)", k),
            last_bad_a[0], last_bad_e[0]);
      check(bad[1] == 0, req, $sformatf("downstream digit %0d slot (R2 R5 R8)", k),
            last_bad_a[1], last_bad_e[1]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 8; k++) m_dig[c][k] = '0;
      m_dec[c] = '0;
      m_lvl[c] = '0;
    end
    wait_clk(4);
    // R9: outputs idle while reset is held
    check(dn0 == 8'hFF && dn1 == 8'hFF && sg0 == 8'h00 && sg1 == 8'h00,
          "R9", "reset outputs", {dn0, dn1, sg0, sg1}, 32'hFFFF0000);
    rst_n = 1'b1;
    observe("R9 dark after reset");

    // R1 R3 R6: raw bytes, asymmetric to expose bit order, full intensity
    xfer(16'h0AFF, 16'h0A0F);
    for (int k = 0; k < 8; k++)
      xfer({8'(k + 1), 8'h01 << k}, {8'(k + 1), 8'h80 >> k});
    observe("R1 R3 R6 raw patterns");

    // R8: minimum intensity
    xfer(16'h0A00, 16'h0A00);
    observe("R8 lowest intensity");

    // R7: decoding on every digit, codes 8..15 with stray bits
    xfer(16'h0AFF, 16'h0A07);
    xfer(16'h09FF, 16'h09A5);
    for (int k = 0; k < 8; k++)
      xfer({8'(k + 1), 8'h70 | 8'(k + 8)}, {8'(k + 1), 8'(k) | 8'h80});
    observe("R7 decode codes");

    // R4: unknown addresses leave everything as it was
    xfer(16'h00FF, 16'h0B55);
    xfer(16'hFF00, 16'h1234);
    observe("R4 ignored addresses");

    // R2: only the downstream word changes
    xfer(16'h0000, 16'h03C3);
    observe("R2 chain downstream only");

    // Random rounds
    for (int r = 0; r < 8; r++) begin
      for (int n = 0; n < 6; n++) begin
        logic [15:0] wu, wd;
        wu = 16'($urandom_range(0, 16'hFFFF));
        wd = 16'($urandom_range(0, 16'hFFFF));
        wu[15:8] = 8'($urandom_range(0, 12));
        wd[15:8] = 8'($urandom_range(0, 12));
        xfer(wu, wd);
      end
      observe("R3 R4 R6 R7 R8 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule